// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits on the receive side of a network controller, watching the destination address of an incoming frame as the bits arrive one at a time. A start-of-frame pulse opens a new address. Each bit is then taken on a cycle where the valid strobe is high. After the 48th address bit, the block issues a one-cycle decision that says whether the frame should be kept.

Unicast addresses are compared against a six-byte station address. Each byte keeps its own match flag, and a frame passes only if every byte matches. Multicast addresses are hashed instead. Every address bit also goes through a serial CRC-32 register. When the last bit is taken, the top six bits of that CRC are latched and used to pick one bit of a 64-bit hash table. An all-ones broadcast address can be accepted directly when a separate enable input is set. A host loads the station address and hash bytes through a simple write port, and these values are expected to stay fixed while a frame is in flight.

Top module: `dest_addr_filter`

## Requirements
- R1: A write with `cfg_wr` high loads `cfg_data` into one register. `cfg_sel` values 0 to 5 select station byte i, which holds address bits 8i to 8i+7 (bit 8i in data bit 0). Values 8 to 15 select hash byte j = `cfg_sel` - 8.
- R2: Address bit k is the k-th bit taken after start of frame, counting from k = 0. It is compared with station address bit k.
- R3: When address bit 0 is 0 (unicast), the frame is accepted only if all 48 bits equal the station address. The hash table and `bcast_en` have no effect on unicast frames.
- R4: A CRC register is set to all ones at start of frame. For each bit taken, it shifts left by one, and the polynomial 0x04C11DB7 is XORed in when (old bit 31 XOR the address bit) is 1. The hash index is bits 31..26 of the CRC after the 48th bit, with bit 31 as the index MSB.
- R5: Hash bit n lives in hash byte n/8 at bit n mod 8. A multicast frame (address bit 0 = 1) is accepted when its indexed hash bit is 1, so all-ones hash bytes accept every multicast frame.
- R6: The all-ones broadcast address is accepted whenever `bcast_en` is 1. When `bcast_en` is 0, it is filtered through the hash table like any other multicast frame.
- R7: `decide_vld` is high for exactly one cycle, starting at the clock edge after the edge that takes the 48th address bit. `accept` is 0 whenever `decide_vld` is 0.
- R8: A start-of-frame pulse clears all partial comparison and CRC state, and an aborted address produces no decision. A bit strobed in the same cycle as start of frame is not taken.
- R9: Bits strobed after the 48th bit, up to the next start of frame, are ignored. Cycles with `bit_vld` low carry no bit, so gaps between bits do not change the result.
- R10: Synchronous active-low reset clears `decide_vld`, `accept`, all station bytes and all hash bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse |
| bit_vld | input | 1 | Serial address bit strobe |
| bit_in | input | 1 | Serial address bit |
| bcast_en | input | 1 | Accept the all-ones broadcast address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_data | input | 8 | Register write data |
| decide_vld | output | 1 | Decision valid pulse |
| accept | output | 1 | Frame accepted (valid with decide_vld) |

## Verification
Some properties are checked on every cycle by the in-RTL assertions:
- the decision pulse stays one cycle long;
- `accept` never shows up without `decide_vld`;
- a decision is always preceded by a taken bit two cycles earlier;
- the bit counter never runs past 48;
- start of frame really clears the counter, the byte flags and the CRC.

The bench scenarios are needed for everything that depends on the address value itself:
- exact matching, including a single flipped bit in the first or last byte;
- the hash index derived from the CRC;
- broadcast handling with the enable set and clear;
- aborted addresses, gapped bit streams and trailing bits.

// File: rtl/daf_pkg.sv
// Shared sizes for the destination address filter.
package daf_pkg;
    localparam int ADDR_BITS  = 48;
    localparam int STA_BYTES  = ADDR_BITS / 8;
    localparam int HASH_BITS  = 64;
    localparam int HASH_BYTES = HASH_BITS / 8;
    localparam int IDX_W      = $clog2(HASH_BITS);
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam int SEL_W      = 4;
    localparam int HASH_BASE  = 8;
endpackage

// File: rtl/daf_regfile.sv
// Station address and hash table storage written by the host.
// Assumes the host does not rewrite entries while a frame is being filtered.
// Selects 0..STA_BYTES-1 hit station bytes; HASH_BASE.. hit hash bytes.
module daf_regfile #(
    parameter int STA_BYTES  = daf_pkg::STA_BYTES,
    parameter int HASH_BYTES = daf_pkg::HASH_BYTES,
    parameter int SEL_W      = daf_pkg::SEL_W,
    parameter int HASH_BASE  = daf_pkg::HASH_BASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [7:0]              cfg_data,
    output logic [STA_BYTES*8-1:0]  station,
    output logic [HASH_BYTES*8-1:0] hash_tbl
);
    logic [7:0] sta_q  [STA_BYTES];
    logic [7:0] hash_q [HASH_BYTES];

    // Store one byte per write into whichever entry the select decodes to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STA_BYTES; i++)  sta_q[i]  <= '0;
            for (int j = 0; j < HASH_BYTES; j++) hash_q[j] <= '0;
        end else if (cfg_wr) begin
            for (int i = 0; i < STA_BYTES; i++)
                if (int'(cfg_sel) == i) sta_q[i] <= cfg_data;
            for (int j = 0; j < HASH_BYTES; j++)
                if (int'(cfg_sel) == HASH_BASE + j) hash_q[j] <= cfg_data;
        end
    end

    // Flatten the arrays so bit n of each vector is address / filter bit n.
    for (genvar g = 0; g < STA_BYTES; g++) begin : g_sta
        assign station[g*8 +: 8] = sta_q[g];
    end
    for (genvar h = 0; h < HASH_BYTES; h++) begin : g_hash
        assign hash_tbl[h*8 +: 8] = hash_q[h];
    end
endmodule

// File: rtl/daf_addr_track.sv
// Counts serial address bits and keeps one match flag per station byte,
// plus the multicast flag (first bit) and an all-ones flag for broadcast.
// Assumes bit k of the station vector is the k-th address bit on the wire.
module daf_addr_track #(
    parameter int ADDR_BITS = daf_pkg::ADDR_BITS,
    localparam int NBYTES   = ADDR_BITS / 8,
    localparam int CW       = $clog2(ADDR_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof,
    input  logic                 bit_vld,
    input  logic                 bit_in,
    input  logic [ADDR_BITS-1:0] station,
    output logic                 take_bit,
    output logic                 last_bit,
    output logic [NBYTES-1:0]    byte_ok,
    output logic                 mcast,
    output logic                 all_ones,
    output logic                 done_q
);
    logic [CW-1:0] cnt;
    logic          ref_bit;

    // A bit is taken only outside start of frame and before the address is full.
    always_comb begin
        take_bit = bit_vld && !sof && (int'(cnt) < ADDR_BITS);
        last_bit = take_bit && (int'(cnt) == ADDR_BITS - 1);
        ref_bit  = station[cnt];
    end

    // Bit position counter, saturating once the full address is in.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) cnt <= '0;
        else if (take_bit) cnt <= cnt + 1'b1;
    end

    // Multicast flag from bit 0, all-ones flag from every bit.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) begin
            mcast    <= 1'b0;
            all_ones <= 1'b1;
        end else if (take_bit) begin
            if (cnt == '0) mcast <= bit_in;
            if (!bit_in)   all_ones <= 1'b0;
        end
    end

    // One match flag per byte, dropped on the first differing bit in that byte.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n || sof) byte_ok[g] <= 1'b1;
            else if (take_bit && (cnt[CW-1:3] == (CW-3)'(g)) && (bit_in != ref_bit))
                byte_ok[g] <= 1'b0;
        end
    end

    // Marks the cycle after the final address bit was taken.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) done_q <= 1'b0;
        else done_q <= last_bit;
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= ADDR_BITS);
    // R8
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt == '0) && (&byte_ok) && all_ones && !done_q);
endmodule

// File: rtl/daf_crc_hash.sv
// Serial CRC over the address bits; latches the hash index at the last bit.
// Assumes take_bit / last_bit come from the address tracker.
module daf_crc_hash #(
    parameter int              CRC_W = daf_pkg::CRC_W,
    parameter logic [CRC_W-1:0] POLY = daf_pkg::CRC_POLY,
    parameter int              IDX_W = daf_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             take_bit,
    input  logic             bit_in,
    input  logic             last_bit,
    output logic [IDX_W-1:0] idx
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    logic             fb;

    // Next CRC value for the bit currently offered.
    always_comb begin
        fb      = crc_q[CRC_W-1] ^ bit_in;
        crc_nxt = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // CRC register, preset at start of frame, stepped per taken bit.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) crc_q <= '1;
        else if (take_bit) crc_q <= crc_nxt;
    end

    // Capture the top CRC bits as the hash index when the last bit enters.
    always_ff @(posedge clk) begin
        if (!rst_n) idx <= '0;
        else if (last_bit) idx <= crc_nxt[CRC_W-1 -: IDX_W];
    end

    // R4
    crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (crc_q == '1));
    // R9
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_bit && !sof) |=> $stable(crc_q));
endmodule

// File: rtl/dest_addr_filter.sv
// Destination address filter top: exact station match for unicast,
// CRC-indexed hash lookup for multicast, optional broadcast accept.
// Assumes address bits arrive LSB of station byte 0 first.
module dest_addr_filter #(
    parameter int ADDR_BITS  = daf_pkg::ADDR_BITS,
    parameter int HASH_BITS  = daf_pkg::HASH_BITS,
    parameter int SEL_W      = daf_pkg::SEL_W,
    localparam int NBYTES    = ADDR_BITS / 8,
    localparam int HBYTES    = HASH_BITS / 8,
    localparam int IDX_W     = $clog2(HASH_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             bcast_en,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [7:0]       cfg_data,
    output logic             decide_vld,
    output logic             accept
);
    logic [ADDR_BITS-1:0] station;
    logic [HASH_BITS-1:0] hash_tbl;
    logic                 take_bit, last_bit, mcast, all_ones, done_q;
    logic [NBYTES-1:0]    byte_ok;
    logic [IDX_W-1:0]     idx;
    logic                 verdict;

    daf_regfile #(.STA_BYTES(NBYTES), .HASH_BYTES(HBYTES), .SEL_W(SEL_W),
                  .HASH_BASE(daf_pkg::HASH_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .station(station), .hash_tbl(hash_tbl));

    daf_addr_track #(.ADDR_BITS(ADDR_BITS)) u_track (
        .clk(clk), .rst_n(rst_n), .sof(sof), .bit_vld(bit_vld), .bit_in(bit_in),
        .station(station), .take_bit(take_bit), .last_bit(last_bit),
        .byte_ok(byte_ok), .mcast(mcast), .all_ones(all_ones), .done_q(done_q));

    daf_crc_hash #(.CRC_W(daf_pkg::CRC_W), .POLY(daf_pkg::CRC_POLY),
                   .IDX_W(IDX_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .sof(sof), .take_bit(take_bit),
        .bit_in(bit_in), .last_bit(last_bit), .idx(idx));

    // Combine the unicast, broadcast and hash results into one verdict.
    always_comb begin
        if (mcast) verdict = (bcast_en && all_ones) || hash_tbl[idx];
        else       verdict = &byte_ok;
    end

    // Register the decision pulse; a new frame start cancels a pending one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decide_vld <= 1'b0;
            accept     <= 1'b0;
        end else begin
            decide_vld <= done_q && !sof;
            accept     <= done_q && !sof && verdict;
        end
    end

    // R7
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide_vld |=> !decide_vld);
    // R7
    accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> decide_vld);
    // R7
    decide_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide_vld |-> $past(bit_vld, 2));
    // R8
    sof_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !decide_vld);
endmodule

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;
    localparam logic [47:0] STA  = 48'h5A13_C477_092E;
    localparam logic [31:0] POLY = 32'h04C11DB7;
    localparam int NV = 12;
    // {address, bcast_en, hash mode}; mode 0 none, 1 all, 2 only index, 3 all but index
    localparam logic [50:0] VECS [NV] = '{
        {48'h5A13_C477_092E, 1'b1, 2'd0},
        {48'hDA13_C477_092E, 1'b0, 2'd1},
        {48'h5A13_C477_092C, 1'b0, 2'd1},
        {48'h0000_0000_0001, 1'b0, 2'd0},
        {48'h0000_0000_0001, 1'b0, 2'd1},
        {48'h0000_0000_0001, 1'b0, 2'd2},
        {48'h0000_0000_0001, 1'b1, 2'd3},
        {48'hFFFF_FFFF_FFFF, 1'b1, 2'd0},
        {48'hFFFF_FFFF_FFFF, 1'b0, 2'd0},
        {48'hFFFF_FFFF_FFFF, 1'b0, 2'd2},
        {48'h3C5F_00A1_B2C3, 1'b0, 2'd2},
        {48'h1234_5678_9ABC, 1'b0, 2'd1}
    };

    logic clk = 0, rst_n = 0, sof = 0, bit_vld = 0, bit_in = 0, bcast_en = 0;
    logic cfg_wr = 0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic decide_vld, accept;
    int nvec = 0, nerr = 0;

    always #10 clk = ~clk;

    dest_addr_filter uut (.clk(clk), .rst_n(rst_n), .sof(sof), .bit_vld(bit_vld),
        .bit_in(bit_in), .bcast_en(bcast_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .decide_vld(decide_vld), .accept(accept));

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int k = 0; k < 48; k++) begin
            logic fb = c[31] ^ a[k];
            c = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
        end
        return c[31:26];
    endfunction

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_data = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic load_hash(input logic [1:0] mode, input logic [5:0] ix);
        for (int j = 0; j < 8; j++) begin
            logic [7:0] one = (int'(ix[5:3]) == j) ? (8'h1 << ix[2:0]) : 8'h0;
            case (mode)
                2'd0: wr(4'(8 + j), 8'h00);
                2'd1: wr(4'(8 + j), 8'hFF);
                2'd2: wr(4'(8 + j), one);
                default: wr(4'(8 + j), ~one);
            endcase
        end
    endtask

    // Sends one address; checks R7 timing and returns the accept value seen.
    task automatic run_frame(input logic [47:0] a, input int gap, input bit sof_bit,
                             input string tag, output logic acc);
        bit early = 0;
        @(negedge clk); sof = 1; bit_vld = sof_bit; bit_in = ~a[0];
        for (int k = 0; k < 48; k++) begin
            if (k > 0)
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk); bit_vld = 0;
                    if (decide_vld) early = 1;
                end
            @(negedge clk); sof = 0; bit_vld = 1; bit_in = a[k];
            if (decide_vld) early = 1;
        end
        @(negedge clk); bit_vld = 0;
        check(!early && !decide_vld, {"R7 no early decision ", tag}, decide_vld, 0);
        @(negedge clk);
        check(decide_vld === 1'b1, {"R7 decision pulse ", tag}, decide_vld, 1);
        acc = accept;
        @(negedge clk);
        check(decide_vld === 1'b0 && accept === 1'b0, {"R7 pulse ends ", tag},
              {decide_vld, accept}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        check(decide_vld === 1'b0 && accept === 1'b0, "R10 outputs in reset",
              {decide_vld, accept}, 0);
        rst_n = 1;
        // R10: cleared station matches the all-zero unicast; cleared hash rejects multicast
        run_frame(48'h0, 0, 0, "R10 zero station", acc);
        check(acc === 1'b1, "R10 zero station accepts zero address", acc, 1);
        run_frame(48'h1, 0, 0, "R10 empty hash", acc);
        check(acc === 1'b0, "R10 empty hash rejects multicast", acc, 0);
        // R1: program station bytes
        for (int i = 0; i < 6; i++) wr(4'(i), STA[8*i +: 8]);

        // Vector table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [47:0] a  = VECS[v][50:3];
            logic        bc = VECS[v][2];
            logic [1:0]  md = VECS[v][1:0];
            logic        ex;
            load_hash(md, hash_idx(a));
            bcast_en = bc;
            if (!a[0])                 ex = (a == STA);
            else if (bc && (&a))       ex = 1'b1;
            else                       ex = (md == 2'd1) || (md == 2'd2);
            run_frame(a, 0, 0, $sformatf("R3 R5 R6 vector %0d", v), acc);
            check(acc === ex, $sformatf("R2 R4 vector %0d verdict", v), acc, ex);
        end

        // R8: aborted address with wrong bits, then a full station frame
        load_hash(2'd0, 6'd0);
        bcast_en = 0;
        @(negedge clk); sof = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); sof = 0; bit_vld = 1; bit_in = ~STA[k];
        end
        run_frame(STA, 0, 0, "R8 after abort", acc);
        check(acc === 1'b1, "R8 abort leaves no stale mismatch", acc, 1);
        // R8: bit strobed during sof is not taken
        run_frame(STA, 0, 1, "R8 sof bit", acc);
        check(acc === 1'b1, "R8 bit with sof ignored", acc, 1);
        // R8: frame restarted 47 bits in never decides on the first try
        @(negedge clk); sof = 1; bit_vld = 0;
        for (int k = 0; k < 47; k++) begin
            @(negedge clk); sof = 0; bit_vld = 1; bit_in = STA[k];
        end
        @(negedge clk); bit_vld = 0; sof = 1;
        @(negedge clk); sof = 0;
        @(negedge clk);
        check(decide_vld === 1'b0, "R8 aborted address gives no decision", decide_vld, 0);

        // R9: gapped bits
        run_frame(STA, 2, 0, "R9 gaps", acc);
        check(acc === 1'b1, "R9 gapped station accepted", acc, 1);
        // R9: trailing bits after a full address are ignored
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); bit_vld = 1; bit_in = k[0];
            check(decide_vld === 1'b0, "R9 trailing bits no decision", decide_vld, 0);
        end
        @(negedge clk); bit_vld = 0;
        @(negedge clk);
        check(decide_vld === 1'b0, "R9 trailing bits no late decision", decide_vld, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule